// File: doc/BRIEF.md
# Retriggering Activity Overflow Counter

This block measures how bursty a stream of activity is. An upstream speedup counter emits a one-cycle trigger each time it is armed and holds a level high while it runs. Each trigger opens a measurement window of a fixed number of millisecond ticks (100 by default). If the window runs out while the speedup level is still high, an 8-bit overflow count goes up by one and a fresh window opens at once. If the speedup level drops before the window runs out, the window stops and nothing is counted.

Software reads the count on `ovf_cnt_o` and writes it through a one-cycle write port. Writing zero starts a new evaluation. The count saturates at its all-ones value. Control is a two-state machine. In `ST_IDLE` no window is open. In `ST_WINDOW` a window is timing. The transitions are:
- `START`: `ST_IDLE` to `ST_WINDOW` on a trigger.
- `RESTART`: `ST_WINDOW` to `ST_WINDOW` on a trigger. The window goes back to zero.
- `LAPSE`: `ST_WINDOW` to `ST_IDLE` when the level is low and no trigger is present.
- `EXPIRE`: `ST_WINDOW` to `ST_WINDOW` on the last tick of a window while the level is high. The count goes up and the window restarts.
- `HOLD`: any state back to itself otherwise.

Top module: `act_ovf_counter`

## Requirements
- R1: After reset the count reads 00h and no window is open.
- R2: A trigger opens a window at tick count zero. The count rises by one on the clock edge that samples the WIN_MS-th millisecond tick after the trigger, provided the speedup level stayed high. After WIN_MS-1 ticks the count is unchanged.
- R3: After an increment the window restarts by itself. While the level stays high, the next increment comes WIN_MS ticks later with no new trigger.
- R4: If the level is low in a cycle with no trigger while a window is open, the window closes with no increment. Later ticks do not change the count until the next trigger, even if the level is high again.
- R5: A trigger during an open window resets its tick count to zero. A full WIN_MS ticks are then needed after that trigger.
- R6: The count is an unsigned 8-bit value that stops at FFh. An expiry at FFh leaves it at FFh.
- R7: A write cycle loads the written byte into the count on the next edge. Writing 00h clears it. A write takes precedence over an expiry in the same cycle.
- R8: The count changes only on a write cycle or on a cycle that carries a millisecond tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | One-cycle trigger from the speedup counter |
| spd_active_i | input | 1 | High while the speedup counter is running |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| wr_en_i | input | 1 | Software write strobe for the count |
| wr_data_i | input | CNT_W | Byte written to the count |
| ovf_cnt_o | output | CNT_W | Current overflow count, readable by software |

## Verification
The hardest case to reach is a write that lands on the exact cycle of a window expiry. It needs WIN_MS-1 ticks counted exactly after a trigger, with the level held high. The bench then issues the final tick and the write strobe together in one cycle. Saturation is reached by writing FEh and running two full windows, so the 255 expiries do not have to be run one by one. A behavioural reference model is compared against the count on every cycle, so that all the lapse and retrigger boundaries are covered too.

// File: rtl/act_ovf_pkg.sv
package act_ovf_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_WINDOW = 1'b1
    } ovf_state_t;
endpackage

// File: rtl/act_ovf_window_timer.sv
module act_ovf_window_timer #(
    parameter int WIN_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    input  logic tick_i,
    output logic at_last_o,
    output logic [$clog2(WIN_MS+1)-1:0] win_cnt_o
);
    localparam int TW = $clog2(WIN_MS + 1);
    localparam logic [TW-1:0] LAST = TW'(WIN_MS - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (adv_i && tick_i) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_last_o = (cnt_q == LAST);
    assign win_cnt_o = cnt_q;
endmodule

// File: rtl/act_ovf_ctrl_fsm.sv
module act_ovf_ctrl_fsm
    import act_ovf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic       spd_active_i,
    input  logic       tick_i,
    input  logic       at_last_i,
    output logic       clr_o,
    output logic       adv_o,
    output logic       inc_o,
    output ovf_state_t state_o
);
    ovf_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        clr_o   = 1'b0;
        adv_o   = 1'b0;
        inc_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_i) begin          // START
                    clr_o   = 1'b1;
                    state_d = ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (trig_i) begin          // RESTART
                    clr_o = 1'b1;
                end else if (!spd_active_i) begin   // LAPSE
                    clr_o   = 1'b1;
                    state_d = ST_IDLE;
                end else begin             // HOLD or EXPIRE
                    adv_o = 1'b1;
                    inc_o = tick_i && at_last_i;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/act_ovf_sat_counter.sv
module act_ovf_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (inc_i && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/act_ovf_counter.sv
module act_ovf_counter
    import act_ovf_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int WIN_MS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             spd_active_i,
    input  logic             ms_tick_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] ovf_cnt_o
);
    localparam int TW = $clog2(WIN_MS + 1);

    logic          win_clr, win_adv, win_last, ovf_inc;
    logic [TW-1:0] win_cnt;
    ovf_state_t    state_q;

    act_ovf_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_i),
        .spd_active_i (spd_active_i),
        .tick_i       (ms_tick_i),
        .at_last_i    (win_last),
        .clr_o        (win_clr),
        .adv_o        (win_adv),
        .inc_o        (ovf_inc),
        .state_o      (state_q)
    );

    act_ovf_window_timer #(.WIN_MS(WIN_MS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (win_clr),
        .adv_i     (win_adv),
        .tick_i    (ms_tick_i),
        .at_last_o (win_last),
        .win_cnt_o (win_cnt)
    );

    act_ovf_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (wr_en_i),
        .ld_val_i (wr_data_i),
        .inc_i    (ovf_inc),
        .cnt_o    (ovf_cnt_o)
    );
endmodule

// File: rtl/act_ovf_counter_chk.sv
module act_ovf_counter_chk
    import act_ovf_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int WIN_MS = 100
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        trig_i,
    input logic                        ms_tick_i,
    input logic                        wr_en_i,
    input logic [CNT_W-1:0]            wr_data_i,
    input logic [CNT_W-1:0]            ovf_cnt_o,
    input logic [$clog2(WIN_MS+1)-1:0] win_cnt,
    input ovf_state_t                  state_q
);
    a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (win_cnt == '0));

    a_r5_retrigger_zero: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (win_cnt == '0));

    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ((ovf_cnt_o == $past(ovf_cnt_o)) ||
                      ({1'b0, ovf_cnt_o} == {1'b0, $past(ovf_cnt_o)} + 1'b1)));

    a_r4_idle_no_inc: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !wr_en_i) |=> $stable(ovf_cnt_o));

    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_cnt_o == {CNT_W{1'b1}}) && !wr_en_i) |=> (ovf_cnt_o == {CNT_W{1'b1}}));

    a_r7_write_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (ovf_cnt_o == $past(wr_data_i)));

    a_r8_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick_i && !wr_en_i) |=> $stable(ovf_cnt_o));
endmodule

bind act_ovf_counter act_ovf_counter_chk #(.CNT_W(CNT_W), .WIN_MS(WIN_MS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig_i),
    .ms_tick_i (ms_tick_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ovf_cnt_o (ovf_cnt_o),
    .win_cnt   (win_cnt),
    .state_q   (state_q)
);

// File: tb/act_ovf_counter_bench.sv
`timescale 1ns/1ps
module act_ovf_counter_bench;
    localparam int CNT_W  = 8;
    localparam int WIN_MS = 100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_i = 1'b0;
    logic             spd_active_i = 1'b0;
    logic             ms_tick_i = 1'b0;
    logic             wr_en_i = 1'b0;
    logic [CNT_W-1:0] wr_data_i = '0;
    logic [CNT_W-1:0] ovf_cnt_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference
    bit m_open = 0;
    int m_ticks = 0;
    int m_cnt = 0;

    always #4 clk = ~clk;

    act_ovf_counter #(.CNT_W(CNT_W), .WIN_MS(WIN_MS)) u_act_ovf_counter (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .spd_active_i(spd_active_i),
        .ms_tick_i(ms_tick_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .ovf_cnt_o(ovf_cnt_o)
    );

    always @(posedge clk) begin
        bit bump;
        bump = 0;
        if (!rst_n) begin
            m_open = 0; m_ticks = 0; m_cnt = 0;
        end else begin
            if (trig_i) begin
                m_open = 1; m_ticks = 0;
            end else if (m_open && !spd_active_i) begin
                m_open = 0; m_ticks = 0;
            end else if (m_open && ms_tick_i) begin
                m_ticks++;
                if (m_ticks == WIN_MS) begin
                    m_ticks = 0; bump = 1;
                end
            end
            if (wr_en_i) m_cnt = int'(wr_data_i);
            else if (bump && m_cnt < 255) m_cnt++;
        end
    end

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) check(cur_req, int'(ovf_cnt_o), m_cnt);
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(bit trg, bit tck, bit we, logic [CNT_W-1:0] wd);
        @(negedge clk);
        trig_i = trg; ms_tick_i = tck; wr_en_i = we; wr_data_i = wd;
    endtask

    task automatic idle_cycle();
        step(0, 0, 0, '0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            step(0, 1, 0, '0);
            step(0, 0, 0, '0);
        end
    endtask

    task automatic expect_cnt(string req, int exp);
        idle_cycle();
        @(negedge clk);
        check(req, int'(ovf_cnt_o), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(ovf_cnt_o), 0);
        rst_n = 1'b1;
        idle_cycle();
        check("R1", int'(ovf_cnt_o), 0);

        // R2: first window
        cur_req = "R2";
        spd_active_i = 1'b1;
        step(1, 0, 0, '0);
        ticks(WIN_MS - 1);
        expect_cnt("R2", 0);
        ticks(1);
        expect_cnt("R2", 1);

        // R3: automatic restart
        cur_req = "R3";
        ticks(WIN_MS);
        expect_cnt("R3", 2);

        // R4: lapse closes window
        cur_req = "R4";
        step(1, 0, 0, '0);
        ticks(50);
        @(negedge clk); spd_active_i = 1'b0;
        idle_cycle();
        @(negedge clk); spd_active_i = 1'b1;
        ticks(2 * WIN_MS);
        expect_cnt("R4", 2);

        // R5: retrigger restarts window
        cur_req = "R5";
        step(1, 0, 0, '0);
        ticks(60);
        step(1, 0, 0, '0);
        ticks(60);
        expect_cnt("R5", 2);
        ticks(40);
        expect_cnt("R5", 3);

        // R8: no ticks, no change
        cur_req = "R8";
        repeat (300) idle_cycle();
        expect_cnt("R8", 3);

        // R7: write clears
        cur_req = "R7";
        step(0, 0, 1, 8'h00);
        expect_cnt("R7", 0);

        // R6: saturation
        cur_req = "R6";
        step(0, 0, 1, 8'hFE);
        step(1, 0, 0, '0);
        ticks(WIN_MS);
        expect_cnt("R6", 255);
        ticks(WIN_MS);
        expect_cnt("R6", 255);

        // R7: write wins over same-cycle expiry
        cur_req = "R7";
        step(0, 0, 1, 8'h05);
        step(1, 0, 0, '0);
        ticks(WIN_MS - 1);
        step(0, 1, 1, 8'h10);
        expect_cnt("R7", 16);
        ticks(WIN_MS);
        expect_cnt("R7", 17);

        repeat (4) idle_cycle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule